// File: doc/BRIEF.md
# Escaped Word-Stream Frame Extractor

This block sits behind a CPU extraction queue that delivers frames as a stream of 32-bit words. Each frame starts with a fixed-length internal header. The block takes the source port and a 32-bit timestamp out of that header, then rebuilds the payload word by word. Frame boundaries are not marked by sideband signals. They are marked by reserved in-band code words of the form 0x8000000x. An escape code lets a payload word that happens to match a code pass through unchanged.

Each payload word leaves on a one-cycle data strobe. The end of a frame is reported by a completion pulse that carries a good or discard flag. A good frame also carries its length in bytes, which excludes the 4-byte FCS. If the header names a port outside the configured range, the block raises a flush request instead of starting a frame. The external queue logic is then expected to drain the queue. The block waits for the next header.

Top module: `xtr_word_deframer`

## Requirements
- R1: After reset, out_valid, done, done_good, hdr_valid and flush_req are low, and the block expects header word 0.
- R2: The block counts HDR_WORDS header words. In the cycle after the last one, it pulses hdr_valid. It presents tstamp = {word0[15:0], word1[31:16]} and src_port = word7[20:14]. This follows from the header bytes being numbered big-endian within each word: the timestamp is bytes 2..5, and the port is bits 7:1 of bytes 27..30 shifted right by 5.
- R3: If the decoded port is NUM_PORTS or higher, flush_req pulses instead of hdr_valid. The block then expects a new header, and no frame data or completion follows.
- R4: A payload word that is not a code is output unchanged on out_data, with a one-cycle out_valid in the next cycle. It adds 4 bytes to the running count.
- R5: The codes 0x80000000..0x80000003 end the frame with done and done_good high. frame_len is the running count minus the code's low two bits, minus 4 for the FCS.
- R6: After code 0x80000006, the next word is output as payload, even when it equals a code value. The escape code itself produces no output.
- R7: After code 0x80000004, the next word is output as payload. In the same cycle the frame ends with done high and done_good low.
- R8: Code 0x80000005 ends the frame at once with done high, done_good low and no payload output.
- R9: Code 0x80000007 produces no payload and no completion, and the frame goes on. A cycle with in_valid low has no effect.
- R10: When swap_en is high, the incoming word is byte-reversed before it is compared with the codes. For example, 0x02000080 is end-of-frame with 2 dropped bytes. Payload is always output as received.
- R11: An end-of-frame code that would give a negative length ends the frame as discarded (done_good low). A frame is never reported good without an end-of-frame code. On a discard, frame_len is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| swap_en | input | 1 | Byte-reverse words before code comparison |
| in_valid | input | 1 | in_word carries a queue word this cycle |
| in_word | input | 32 | Word from the extraction queue |
| out_valid | output | 1 | out_data holds a payload word |
| out_data | output | 32 | Payload word |
| hdr_valid | output | 1 | Header decoded; src_port and tstamp updated |
| src_port | output | 7 | Source port from the header |
| tstamp | output | 32 | Timestamp from the header |
| flush_req | output | 1 | Header named an out-of-range port; queue must be flushed |
| done | output | 1 | Frame completed this cycle |
| done_good | output | 1 | Completed frame is good (valid with done) |
| frame_len | output | LEN_W | Frame length in bytes without FCS (valid with done_good) |

## Verification
The checker watches several properties on every cycle. It checks that a good completion is always a completion, and that flush and header-done never coincide. It checks that every data strobe and completion follows an accepted input word. It checks that an abort code in the payload phase is followed at once by a discard with no data, and that a not-ready code is followed by silence. Length arithmetic, header field extraction, escape and prune sequencing, byte-swapped code matching and the out-of-range port path can only be shown by the bench. The bench runs them through whole frames and compares each output with a behavioural model on every clock.

// File: rtl/xtr_word_deframer.sv
module xtr_word_deframer #(
  parameter int HDR_WORDS = 9,
  parameter int NUM_PORTS = 65,
  parameter int LEN_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_en,
  input  logic             in_valid,
  input  logic [31:0]      in_word,
  output logic             out_valid,
  output logic [31:0]      out_data,
  output logic             hdr_valid,
  output logic [6:0]       src_port,
  output logic [31:0]      tstamp,
  output logic             flush_req,
  output logic             done,
  output logic             done_good,
  output logic [LEN_W-1:0] frame_len
);
  localparam int HCW = $clog2(HDR_WORDS + 1);

  logic             in_hdr, esc, prn;
  logic [HCW-1:0]   hcnt;
  logic [LEN_W-1:0] cnt;
  logic [15:0]      ts_hi, ts_lo;
  logic [6:0]       port_r;
  logic [31:0]      cmp;
  logic             is_code;
  logic [6:0]       port_now;
  logic [15:0]      ts_lo_now;
  logic [LEN_W-1:0] need;

  assign cmp       = swap_en ? {in_word[7:0], in_word[15:8], in_word[23:16], in_word[31:24]} : in_word;
  assign is_code   = (cmp[31:3] == 29'h1000_0000);
  assign port_now  = (hcnt == HCW'(7)) ? in_word[20:14] : port_r;
  assign ts_lo_now = (hcnt == HCW'(1)) ? in_word[31:16] : ts_lo;
  assign need      = LEN_W'(4) + LEN_W'(cmp[1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_hdr    <= 1'b1;
      esc       <= 1'b0;
      prn       <= 1'b0;
      hcnt      <= '0;
      cnt       <= '0;
      ts_hi     <= '0;
      ts_lo     <= '0;
      port_r    <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      hdr_valid <= 1'b0;
      src_port  <= '0;
      tstamp    <= '0;
      flush_req <= 1'b0;
      done      <= 1'b0;
      done_good <= 1'b0;
      frame_len <= '0;
    end else begin
      out_valid <= 1'b0;
      hdr_valid <= 1'b0;
      flush_req <= 1'b0;
      done      <= 1'b0;
      done_good <= 1'b0;
      if (in_valid) begin
        if (in_hdr) begin
          if (hcnt == HCW'(0)) ts_hi <= in_word[15:0];
          ts_lo  <= ts_lo_now;
          port_r <= port_now;
          if (hcnt == HCW'(HDR_WORDS - 1)) begin
            hcnt <= '0;
            if (32'(port_now) >= NUM_PORTS) begin
              flush_req <= 1'b1;
            end else begin
              hdr_valid <= 1'b1;
              src_port  <= port_now;
              tstamp    <= {ts_hi, ts_lo_now};
              in_hdr    <= 1'b0;
              cnt       <= '0;
            end
          end else begin
            hcnt <= hcnt + HCW'(1);
          end
        end else if (esc) begin
          out_valid <= 1'b1;
          out_data  <= in_word;
          cnt       <= cnt + LEN_W'(4);
          esc       <= 1'b0;
          if (prn) begin
            prn       <= 1'b0;
            done      <= 1'b1;
            frame_len <= '0;
            in_hdr    <= 1'b1;
          end
        end else if (is_code) begin
          case (cmp[2:0])
            3'd4: begin esc <= 1'b1; prn <= 1'b1; end
            3'd5: begin done <= 1'b1; frame_len <= '0; in_hdr <= 1'b1; end
            3'd6: esc <= 1'b1;
            3'd7: ;
            default: begin
              done   <= 1'b1;
              in_hdr <= 1'b1;
              if (cnt >= need) begin
                done_good <= 1'b1;
                frame_len <= cnt - need;
              end else begin
                frame_len <= '0;
              end
            end
          endcase
        end else begin
          out_valid <= 1'b1;
          out_data  <= in_word;
          cnt       <= cnt + LEN_W'(4);
        end
      end
    end
  end
endmodule

// File: rtl/xtr_word_deframer_chk.sv
module xtr_word_deframer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        swap_en,
  input logic        in_valid,
  input logic [31:0] in_word,
  input logic        out_valid,
  input logic        hdr_valid,
  input logic        flush_req,
  input logic        done,
  input logic        done_good,
  input logic        in_hdr,
  input logic        esc
);
  logic [31:0] c;
  assign c = swap_en ? {in_word[7:0], in_word[15:8], in_word[23:16], in_word[31:24]} : in_word;

  assert_good_is_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_good |-> done);
  assert_flush_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(flush_req && hdr_valid));
  assert_data_needs_input_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid === 1'b0 |=> !out_valid && !done && !hdr_valid && !flush_req);
  assert_abort_discard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_hdr && !esc && c == 32'h8000_0005) |=> done && !done_good && !out_valid);
  assert_not_ready_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_hdr && !esc && c == 32'h8000_0007) |=> !done && !out_valid);
endmodule

bind xtr_word_deframer xtr_word_deframer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .hdr_valid(hdr_valid), .flush_req(flush_req), .done(done),
  .done_good(done_good), .in_hdr(in_hdr), .esc(esc)
);

// File: tb/sim_xtr_word_deframer.sv
module sim_xtr_word_deframer;
  localparam int HDR = 9;
  localparam int NP  = 65;

  logic clk = 1'b0, rst_n = 1'b0, swap_en = 1'b0, in_valid = 1'b0;
  logic [31:0] in_word = '0;
  logic out_valid, hdr_valid, flush_req, done, done_good;
  logic [31:0] out_data, tstamp;
  logic [6:0] src_port;
  logic [15:0] frame_len;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xtr_word_deframer #(.HDR_WORDS(HDR), .NUM_PORTS(NP), .LEN_W(16)) u0 (
    .clk(clk), .rst_n(rst_n), .swap_en(swap_en), .in_valid(in_valid), .in_word(in_word),
    .out_valid(out_valid), .out_data(out_data), .hdr_valid(hdr_valid), .src_port(src_port),
    .tstamp(tstamp), .flush_req(flush_req), .done(done), .done_good(done_good),
    .frame_len(frame_len));

  // reference model state
  bit m_hdr = 1, m_esc = 0, m_prn = 0;
  int m_hc = 0, m_cnt = 0;
  logic [31:0] m_hw[$];
  bit e_ov, e_hv, e_fl, e_dn, e_gd;
  logic [31:0] e_od, e_ts;
  int e_port, e_len;

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model(bit v, logic [31:0] w);
    logic [31:0] c;
    e_ov = 0; e_hv = 0; e_fl = 0; e_dn = 0; e_gd = 0;
    if (!v) return;
    c = swap_en ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    if (m_hdr) begin
      m_hw.push_back(w);
      m_hc++;
      if (m_hc == HDR) begin
        int p;
        p = int'(m_hw[7][20:14]);
        if (p >= NP) e_fl = 1;
        else begin
          e_hv = 1; e_port = p;
          e_ts = {m_hw[0][15:0], m_hw[1][31:16]};
          m_hdr = 0; m_cnt = 0;
        end
        m_hc = 0; m_hw.delete();
      end
    end else if (m_esc) begin
      e_ov = 1; e_od = w; m_cnt += 4; m_esc = 0;
      if (m_prn) begin e_dn = 1; e_len = 0; m_prn = 0; m_hdr = 1; end
    end else if (c >= 32'h8000_0000 && c <= 32'h8000_0007) begin
      int k;
      k = int'(c - 32'h8000_0000);
      if (k <= 3) begin
        e_dn = 1; m_hdr = 1;
        if (m_cnt - k - 4 >= 0) begin e_gd = 1; e_len = m_cnt - k - 4; end
        else e_len = 0;
      end else if (k == 4) begin m_esc = 1; m_prn = 1; end
      else if (k == 5) begin e_dn = 1; e_len = 0; m_hdr = 1; end
      else if (k == 6) m_esc = 1;
    end else begin
      e_ov = 1; e_od = w; m_cnt += 4;
    end
  endtask

  task automatic tick(string tag, bit v, logic [31:0] w);
    in_valid = v; in_word = w;
    @(posedge clk);
    model(v, w);
    #1;
    chk({tag, " out_valid"}, out_valid, e_ov);
    if (e_ov) chk({tag, " out_data R4"}, out_data, e_od);
    chk({tag, " hdr_valid R2"}, hdr_valid, e_hv);
    if (e_hv) begin
      chk({tag, " src_port R2"}, src_port, e_port);
      chk({tag, " tstamp R2"}, tstamp, e_ts);
    end
    chk({tag, " flush_req R3"}, flush_req, e_fl);
    chk({tag, " done"}, done, e_dn);
    chk({tag, " done_good R11"}, done_good, e_gd);
    if (e_dn) chk({tag, " frame_len R5"}, frame_len, e_len);
    in_valid = 0;
  endtask

  task automatic header(string tag, int port, logic [31:0] ts);
    for (int i = 0; i < HDR; i++) begin
      logic [31:0] w;
      w = 32'h0101_0101 * (i + 3);
      if (i == 0) w = {16'hA5A5, ts[31:16]};
      if (i == 1) w = {ts[15:0], 16'h5A5A};
      if (i == 7) w = (32'(port) << 14) | 32'hFF80_0000 | 32'h0000_03FF;
      tick(tag, 1, w);
    end
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset out_valid", out_valid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset hdr_valid", hdr_valid, 0);
    chk("R1 reset flush_req", flush_req, 0);
    rst_n = 1;

    // R2 R4 R5 R9: plain frame, EOF with 2 dropped bytes, not-ready and idle gaps
    header("R2 hdrA", 5, 32'h1122_3344);
    for (int i = 0; i < 16; i++) begin
      tick("R4 dataA", 1, 32'h1000_0000 + i);
      if (i == 6) tick("R9 notready", 1, 32'h8000_0007);
      if (i == 9) tick("R9 idle", 0, 32'h8000_0005);
    end
    tick("R5 eof2", 1, 32'h8000_0002);
    tick("R9 idle2", 0, 32'h0);

    // R6: escaped literal codes, EOF0
    header("R2 hdrB", 64, 32'hDEAD_BEEF);
    for (int i = 0; i < 15; i++) tick("R4 dataB", 1, 32'h2000_0000 + i);
    tick("R6 esc", 1, 32'h8000_0006);
    tick("R6 literal", 1, 32'h8000_0005);
    tick("R6 esc2", 1, 32'h8000_0006);
    tick("R6 literal2", 1, 32'h8000_0000);
    tick("R5 eof0", 1, 32'h8000_0000);

    // R7: pruned frame
    header("R2 hdrC", 0, 32'h0000_0001);
    for (int i = 0; i < 4; i++) tick("R4 dataC", 1, 32'h3000_0000 + i);
    tick("R7 prune", 1, 32'h8000_0004);
    tick("R7 last", 1, 32'hCAFE_F00D);

    // R8: abort
    header("R2 hdrD", 33, 32'h7777_0000);
    for (int i = 0; i < 3; i++) tick("R4 dataD", 1, 32'h4000_0000 + i);
    tick("R8 abort", 1, 32'h8000_0005);

    // R3: out-of-range port, then a normal frame follows
    header("R3 badport", 100, 32'h0);
    header("R3 badport127", 127, 32'h0);
    header("R2 hdrE", 1, 32'hFEDC_BA98);
    for (int i = 0; i < 17; i++) tick("R4 dataE", 1, 32'h5000_0000 + i);
    tick("R5 eof3", 1, 32'h8000_0003);

    // R10: byte-swapped comparison
    swap_en = 1;
    header("R10 hdrF", 9, 32'h0BAD_CAFE);
    tick("R10 raw code is data", 1, 32'h8000_0000);
    tick("R10 raw code is data2", 1, 32'h8000_0005);
    for (int i = 0; i < 14; i++) tick("R10 dataF", 1, 32'h6000_0000 + i);
    tick("R10 nr swapped", 1, 32'h0700_0080);
    tick("R10 esc swapped", 1, 32'h0600_0080);
    tick("R10 literal", 1, 32'h0500_0080);
    tick("R10 eof1 swapped", 1, 32'h0100_0080);
    swap_en = 0;

    // R11: EOF without enough bytes
    header("R11 hdrG", 2, 32'h1);
    tick("R11 eof3 empty", 1, 32'h8000_0003);
    header("R11 hdrH", 2, 32'h2);
    tick("R11 one word", 1, 32'hAAAA_5555);
    tick("R11 eof1 short", 1, 32'h8000_0001);
    header("R11 hdrI", 3, 32'h3);
    tick("R11 one word b", 1, 32'h1234_5678);
    tick("R11 eof0 zero len", 1, 32'h8000_0000);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule